// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block orders the external bus traffic of an atomic read-modify-write or an interrupt-acknowledge pair. It sits in a processor that has a write-back cache and a posted write buffer. When the core asks for an atomic operation, the sequencer first records the cache state of the target line. It then holds the core and waits until the write buffer has emptied. After that it issues commands, one at a time, to a bus-cycle engine. If the line is modified it issues a copy-back. If the line is present it invalidates it. It then issues the locked read. For an atomic update it follows with the locked write. For an interrupt acknowledge it issues a second locked read instead of the write.

Data that sits in the cache is never handed to a locked read, so every locked access reaches the bus. A write-back forced by an external snoop may fall between the locked read and the locked write. That write-back is the only cacheable cycle that can appear while the lock is held. The bus lock indication covers every locked cycle and drops one clock after the last ready. A back-off pulls the current command off the bus and the same command is issued again once it clears, with the lock held throughout. Requests to release the bus (hold) are only granted while no sequence is running.

Top module: `lrmw_seq`

## Requirements
- R1: From the cycle after a request is accepted, `core_stall` is high. While `wbuf_empty` is low, `wbuf_drain` stays high and no command is valid.
- R2: A read-modify-write on an invalid line (`line_state`=0, or 3) issues the locked read (op 2) first. It is preceded by no copy-back and no invalidate, and it goes to the address latched at the request.
- R3: A read-modify-write on a clean line (`line_state`=1) pulses `cache_inval` for one cycle. The locked read is issued in the next cycle.
- R4: A read-modify-write on a modified line (`line_state`=2) issues these in order: a copy-back (op 1) with `cmd_cache` high and `bus_lock` low, then one `cache_inval` pulse, then the locked read to the same address.
- R5: Locked reads (op 2) and locked writes (op 3) carry `cmd_cache` low. In a read-modify-write, the locked write follows the locked read once `mod_ready` is high.
- R6: `bus_lock` is high from the first cycle a locked command is valid until the cycle of the final `cmd_done`. It is low in the cycle after that.
- R7: While a sequence runs, `hold_ack` stays low even if `hold_req` is high. In idle, `hold_ack` follows `hold_req`.
- R8: While `boff` is high, `cmd_valid` is low and `cmd_done` is ignored. `bus_lock` stays high once the lock has begun. After `boff` falls, the same op and address are valid again.
- R9: A `snoop_req` that is present between the locked read and the locked write issues a snoop write-back (op 4) to `snoop_addr`. It carries `cmd_cache` high and `bus_lock` high, and the locked write comes after it.
- R10: An interrupt acknowledge (`lock_kind`=1) issues two locked reads and no copy-back or invalidate, whatever the line state.
- R11: `core_stall` stays high through the final ready. It is low in the cycle after that.
- R12: While `hold_req` is high in idle, `lock_req` is not accepted: `core_stall` stays low and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_req | input | 1 | Core request for an atomic sequence |
| lock_kind | input | 1 | 0 = read-modify-write, 1 = interrupt acknowledge |
| lock_addr | input | AW | Target address, latched at acceptance |
| line_state | input | 2 | Cache state of the target: 0 invalid, 1 clean, 2 modified |
| wbuf_empty | input | 1 | Posted write buffer holds no entries |
| wbuf_drain | output | 1 | Asks the write buffer to flush |
| mod_ready | input | 1 | Modified data is ready for the locked write |
| snoop_req | input | 1 | Snoop hit on a modified line needs a write-back |
| snoop_addr | input | AW | Line address of the snoop write-back |
| snoop_done | output | 1 | Snoop write-back completed |
| hold_req | input | 1 | External request for the bus |
| hold_ack | output | 1 | Bus released to the external master |
| boff | input | 1 | Back-off: abort the current cycle |
| cmd_valid | output | 1 | Command offered to the bus-cycle engine |
| cmd_op | output | 3 | 1 copy-back, 2 locked read, 3 locked write, 4 snoop write-back |
| cmd_addr | output | AW | Command address |
| cmd_cache | output | 1 | Cacheable-cycle indication |
| cmd_done | input | 1 | Final ready of the current command |
| cache_inval | output | 1 | One-cycle invalidate of the latched line |
| bus_lock | output | 1 | Bus lock indication |
| core_stall | output | 1 | Core may issue no further access |

## Verification
The bench runs the read-modify-write through every combination of line state (invalid, clean, modified), bus latency (0 to 2 waits), drain delay (0 to 2 cycles) and snoop presence. These runs separate the three pre-read paths by the commands they issue and by the number of invalidate pulses. They also show whether the lock and the stall follow the final ready rather than a fixed count. Interrupt-acknowledge runs on all line states show that the cache state cannot add traffic. Back-off runs with `hold_req` held high show that the command is issued again with the same op and address under an unbroken lock, and that hold is refused until the sequence ends.

// File: rtl/lrmw_pkg.sv
// Shared types for the locked read-modify-write sequencer.
// Assumes the bus-cycle engine decodes bus_op_e values as listed.
package lrmw_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_CPYBK = 3'd1,
        OP_LRD   = 3'd2,
        OP_LWR   = 3'd3,
        OP_SNWB  = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        LS_INV   = 2'd0,
        LS_CLEAN = 2'd1,
        LS_MOD   = 2'd2
    } line_st_e;

    typedef enum logic [3:0] {
        S_IDLE, S_DRAIN, S_CPYBK, S_INVAL, S_RD,
        S_MID, S_SNWB, S_WR, S_RD2
    } seq_st_e;

    localparam int OPW = $bits(bus_op_e);

    // True for the two op codes that belong to the locked pair itself.
    function automatic logic is_locked_op(input bus_op_e op);
        return (op == OP_LRD) || (op == OP_LWR);
    endfunction

    // True for the op codes that move a dirty line back to memory.
    function automatic logic is_writeback_op(input bus_op_e op);
        return (op == OP_CPYBK) || (op == OP_SNWB);
    endfunction

endpackage

// File: rtl/lrmw_plan.sv
// Chooses the first stage after the write buffer has drained.
// It looks at the sequence kind and the recorded line state.
// Assumes: an interrupt acknowledge never touches the cache, and line state 3
// is treated as invalid.
module lrmw_plan
    import lrmw_pkg::*;
(
    input  logic     kind_inta,
    input  logic [1:0] line_st,
    output seq_st_e  first_st
);

    // Select copy-back, invalidate or a direct locked read.
    always_comb begin
        if (kind_inta) begin
            first_st = S_RD;
        end else begin
            case (line_st)
                LS_MOD:   first_st = S_CPYBK;
                LS_CLEAN: first_st = S_INVAL;
                default:  first_st = S_RD;
            endcase
        end
    end

endmodule

// File: rtl/lrmw_fsm.sv
// Sequence control. It accepts a lock request, drains the write buffer and
// walks through the copy-back, invalidate, locked read, optional snoop
// write-back and locked write (or the second read).
// Assumes: done_ok is a completed bus command, and snoop_addr is held by the
// requester until snoop_done.
module lrmw_fsm
    import lrmw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_req,
    input  logic          lock_kind,
    input  logic [AW-1:0] lock_addr,
    input  logic [1:0]    line_state,
    input  logic          wbuf_empty,
    input  logic          mod_ready,
    input  logic          snoop_req,
    input  logic [AW-1:0] snoop_addr,
    input  logic          hold_req,
    input  logic          done_ok,
    output logic          req_active,
    output bus_op_e       req_op,
    output logic [AW-1:0] req_addr,
    output logic          cache_inval,
    output logic          wbuf_drain,
    output logic          core_stall,
    output logic          hold_ack,
    output logic          snoop_done,
    output logic          final_done
);

    seq_st_e       st, st_nx;
    seq_st_e       first_st;
    logic          kind_q;
    logic [1:0]    ls_q;
    logic [AW-1:0] addr_q;
    logic          accept;

    lrmw_plan u_plan (
        .kind_inta (kind_q),
        .line_st   (ls_q),
        .first_st  (first_st)
    );

    // A request is taken only in idle, and only while no hold is pending.
    assign accept = (st == S_IDLE) && lock_req && !hold_req;

    // Next-state selection for the sequence.
    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:  if (accept) st_nx = S_DRAIN;
            S_DRAIN: if (wbuf_empty) st_nx = first_st;
            S_CPYBK: if (done_ok) st_nx = S_INVAL;
            S_INVAL: st_nx = S_RD;
            S_RD:    if (done_ok) st_nx = S_MID;
            S_MID: begin
                if (snoop_req)      st_nx = S_SNWB;
                else if (kind_q)    st_nx = S_RD2;
                else if (mod_ready) st_nx = S_WR;
            end
            S_SNWB:  if (done_ok) st_nx = S_MID;
            S_WR:    if (done_ok) st_nx = S_IDLE;
            S_RD2:   if (done_ok) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Capture the request attributes at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= 1'b0;
            ls_q   <= 2'd0;
            addr_q <= '0;
        end else if (accept) begin
            kind_q <= lock_kind;
            ls_q   <= line_state;
            addr_q <= lock_addr;
        end
    end

    // Command request decoded from the current stage.
    always_comb begin
        req_active = 1'b1;
        case (st)
            S_CPYBK: req_op = OP_CPYBK;
            S_RD:    req_op = OP_LRD;
            S_RD2:   req_op = OP_LRD;
            S_WR:    req_op = OP_LWR;
            S_SNWB:  req_op = OP_SNWB;
            default: begin
                req_op     = OP_NONE;
                req_active = 1'b0;
            end
        endcase
    end

    assign req_addr    = (st == S_SNWB) ? snoop_addr : addr_q;
    assign cache_inval = (st == S_INVAL);
    assign wbuf_drain  = (st == S_DRAIN);
    assign core_stall  = (st != S_IDLE);
    assign hold_ack    = hold_req && (st == S_IDLE);
    assign snoop_done  = done_ok && (st == S_SNWB);
    assign final_done  = done_ok && ((st == S_WR) || (st == S_RD2));

    // R4: a copy-back stage is only ever reached for a modified line in a read-modify-write.
    assert_cpybk_only_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CPYBK) |-> (ls_q == LS_MOD) && !kind_q);

    // R10: an interrupt acknowledge never reaches the cache invalidate stage.
    assert_inta_no_inval_R10: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q && core_stall |-> (st != S_INVAL) && (st != S_CPYBK));

endmodule

// File: rtl/lrmw_busif.sv
// Command port toward the bus-cycle engine. It applies back-off, qualifies
// ready, sets the cacheable indication and holds the lock indication.
// Assumes: cmd_done is only meaningful while the command is valid.
module lrmw_busif
    import lrmw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_active,
    input  bus_op_e       req_op,
    input  logic [AW-1:0] req_addr,
    input  logic          boff,
    input  logic          cmd_done,
    input  logic          final_done,
    output logic          cmd_valid,
    output bus_op_e       cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic          cmd_cache,
    output logic          bus_lock,
    output logic          done_ok
);

    logic lock_q;
    logic issue_locked;

    assign cmd_valid    = req_active && !boff;
    assign cmd_op       = req_op;
    assign cmd_addr     = req_addr;
    assign cmd_cache    = req_active && is_writeback_op(req_op);
    assign done_ok      = cmd_valid && cmd_done;
    assign issue_locked = cmd_valid && is_locked_op(req_op);
    assign bus_lock     = lock_q || issue_locked;

    // Lock is held from the first locked issue until the final ready.
    always_ff @(posedge clk) begin
        if (!rst_n)          lock_q <= 1'b0;
        else if (final_done) lock_q <= 1'b0;
        else if (issue_locked) lock_q <= 1'b1;
    end

    // R6: the lock drops in the cycle after the final ready.
    assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        final_done |=> !bus_lock);

    // R8: a back-off inside a locked sequence does not drop the lock.
    assert_boff_keeps_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boff && $past(bus_lock) && !$past(final_done) |-> bus_lock);

endmodule

// File: rtl/lrmw_seq.sv
// Top of the locked read-modify-write sequencer. It ties the sequence
// control to the command port.
// Assumes: a single bus-cycle engine that serves one command at a time.
module lrmw_seq
    import lrmw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_req,
    input  logic          lock_kind,
    input  logic [AW-1:0] lock_addr,
    input  logic [1:0]    line_state,
    input  logic          wbuf_empty,
    output logic          wbuf_drain,
    input  logic          mod_ready,
    input  logic          snoop_req,
    input  logic [AW-1:0] snoop_addr,
    output logic          snoop_done,
    input  logic          hold_req,
    output logic          hold_ack,
    input  logic          boff,
    output logic          cmd_valid,
    output logic [OPW-1:0] cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic          cmd_cache,
    input  logic          cmd_done,
    output logic          cache_inval,
    output logic          bus_lock,
    output logic          core_stall
);

    logic          req_active;
    bus_op_e       req_op;
    bus_op_e       op_out;
    logic [AW-1:0] req_addr;
    logic          done_ok;
    logic          final_done;

    lrmw_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_req    (lock_req),
        .lock_kind   (lock_kind),
        .lock_addr   (lock_addr),
        .line_state  (line_state),
        .wbuf_empty  (wbuf_empty),
        .mod_ready   (mod_ready),
        .snoop_req   (snoop_req),
        .snoop_addr  (snoop_addr),
        .hold_req    (hold_req),
        .done_ok     (done_ok),
        .req_active  (req_active),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .cache_inval (cache_inval),
        .wbuf_drain  (wbuf_drain),
        .core_stall  (core_stall),
        .hold_ack    (hold_ack),
        .snoop_done  (snoop_done),
        .final_done  (final_done)
    );

    lrmw_busif #(.AW(AW)) u_busif (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_active (req_active),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .boff       (boff),
        .cmd_done   (cmd_done),
        .final_done (final_done),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_out),
        .cmd_addr   (cmd_addr),
        .cmd_cache  (cmd_cache),
        .bus_lock   (bus_lock),
        .done_ok    (done_ok)
    );

    assign cmd_op = op_out;

    // R1: nothing reaches the bus while the write buffer is being drained.
    assert_drain_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_drain |-> !cmd_valid);

    // R3: an invalidate pulse is followed by the locked read request.
    assert_inval_then_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cache_inval |=> (cmd_op == OP_LRD) && !cache_inval);

    // R5: locked accesses are never marked cacheable.
    assert_locked_uncached_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && ((cmd_op == OP_LRD) || (cmd_op == OP_LWR)) |-> !cmd_cache);

    // R7: the bus is never granted away during a sequence.
    assert_hold_outside_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !bus_lock && !core_stall);

    // R8: back-off removes the command from the bus.
    assert_boff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boff |-> !cmd_valid);

    // R9: a snoop write-back inside the sequence runs under the lock.
    assert_snoop_wb_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == OP_SNWB) |-> bus_lock && cmd_cache);

    // R11: the core is released in the cycle after the final ready.
    assert_stall_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        final_done |=> !core_stall);

endmodule

// File: tb/tb_lrmw_seq.sv
module tb_lrmw_seq;
    import lrmw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_req = 1'b0;
    logic          lock_kind = 1'b0;
    logic [AW-1:0] lock_addr = '0;
    logic [1:0]    line_state = 2'd0;
    logic          wbuf_empty = 1'b1;
    logic          wbuf_drain;
    logic          mod_ready = 1'b1;
    logic          snoop_req = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          snoop_done;
    logic          hold_req = 1'b0;
    logic          hold_ack;
    logic          boff = 1'b0;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic          cmd_cache;
    logic          cmd_done = 1'b0;
    logic          cache_inval;
    logic          bus_lock;
    logic          core_stall;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    lrmw_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .lock_kind(lock_kind),
        .lock_addr(lock_addr), .line_state(line_state), .wbuf_empty(wbuf_empty),
        .wbuf_drain(wbuf_drain), .mod_ready(mod_ready), .snoop_req(snoop_req),
        .snoop_addr(snoop_addr), .snoop_done(snoop_done), .hold_req(hold_req),
        .hold_ack(hold_ack), .boff(boff), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_cache(cmd_cache), .cmd_done(cmd_done),
        .cache_inval(cache_inval), .bus_lock(bus_lock), .core_stall(core_stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Wait for a command, check it, optionally back it off, then complete it.
    task automatic serve(input logic [2:0] eop, input logic [AW-1:0] eaddr, input logic ecache,
                         input logic elock, input int lat, input bit do_boff, input string tag,
                         output int inv_seen);
        int guard = 0;
        inv_seen = 0;
        while (!cmd_valid && guard < 40) begin
            if (cache_inval) inv_seen++;
            @(posedge clk); @(negedge clk);
            guard++;
        end
        chk(cmd_valid == 1'b1, {tag, " valid"}, 32'(cmd_valid), 32'd1);
        chk(cmd_op == eop, {tag, " op"}, 32'(cmd_op), 32'(eop));
        chk(cmd_addr == eaddr, {tag, " addr"}, 32'(cmd_addr), 32'(eaddr));
        chk(cmd_cache == ecache, {tag, " cache R5"}, 32'(cmd_cache), 32'(ecache));
        chk(bus_lock == elock, {tag, " lock R6"}, 32'(bus_lock), 32'(elock));
        chk(core_stall == 1'b1, {tag, " stall R11"}, 32'(core_stall), 32'd1);
        if (hold_req) chk(hold_ack == 1'b0, "R7 hold refused in sequence", 32'(hold_ack), 32'd0);
        if (do_boff) begin
            @(posedge clk); @(negedge clk);
            boff = 1'b1;
            cmd_done = 1'b1;
            #1;
            chk(cmd_valid == 1'b0, "R8 boff removes command", 32'(cmd_valid), 32'd0);
            @(posedge clk); @(negedge clk);
            chk(bus_lock == 1'b1, "R8 lock kept in boff", 32'(bus_lock), 32'd1);
            chk(cmd_valid == 1'b0, "R8 still off", 32'(cmd_valid), 32'd0);
            boff = 1'b0;
            cmd_done = 1'b0;
            #1;
            chk(cmd_valid == 1'b1 && cmd_op == eop && cmd_addr == eaddr, "R8 same cycle reissued",
                {13'd0, cmd_valid, cmd_op, cmd_addr}, {13'd1, 1'b1, eop, eaddr});
        end
        for (int i = 0; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            chk(cmd_valid && cmd_op == eop, {tag, " held"}, 32'(cmd_op), 32'(eop));
        end
        cmd_done = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_done = 1'b0;
    endtask

    // One full sequence with the given configuration.
    task automatic run_seq(input bit kind, input logic [1:0] ls, input int lat, input int dd,
                           input bit snp, input bit bo, input bit hld, input logic [AW-1:0] a);
        int inv;
        int exp_inv;
        wbuf_empty = (dd == 0);
        lock_kind = kind;
        lock_addr = a;
        line_state = ls;
        lock_req = 1'b1;
        @(posedge clk); @(negedge clk);
        lock_req = 1'b0;
        lock_addr = ~a;
        line_state = 2'd0;
        hold_req = hld;
        chk(core_stall == 1'b1, "R1 stall after accept", 32'(core_stall), 32'd1);
        chk(bus_lock == 1'b0, "R6 no lock before lock cycle", 32'(bus_lock), 32'd0);
        for (int i = 0; i < dd; i++) begin
            chk(wbuf_drain == 1'b1 && cmd_valid == 1'b0, "R1 drain blocks bus",
                {30'd0, wbuf_drain, cmd_valid}, 32'd2);
            @(posedge clk); @(negedge clk);
        end
        wbuf_empty = 1'b1;
        if (!kind && ls == 2'd2) begin
            serve(3'(OP_CPYBK), a, 1'b1, 1'b0, lat, 1'b0, "R4 copy-back", inv);
            chk(inv == 0, "R4 no inval before copy-back", 32'(inv), 32'd0);
        end
        if (snp) begin
            snoop_req = 1'b1;
            snoop_addr = a ^ 16'h0F00;
        end
        serve(3'(OP_LRD), a, 1'b0, 1'b1, lat, bo, kind ? "R10 first read" : "R2 locked read", inv);
        exp_inv = (!kind && (ls == 2'd1 || ls == 2'd2)) ? 1 : 0;
        chk(inv == exp_inv, kind ? "R10 no inval" : "R3 inval count", 32'(inv), 32'(exp_inv));
        if (kind) begin
            serve(3'(OP_LRD), a, 1'b0, 1'b1, lat, 1'b0, "R10 second read", inv);
        end else begin
            if (snp) begin
                serve(3'(OP_SNWB), a ^ 16'h0F00, 1'b1, 1'b1, lat, 1'b0, "R9 snoop write-back", inv);
                snoop_req = 1'b0;
            end
            serve(3'(OP_LWR), a, 1'b0, 1'b1, lat, 1'b0, "R5 locked write", inv);
        end
        chk(bus_lock == 1'b0, "R6 lock released", 32'(bus_lock), 32'd0);
        chk(core_stall == 1'b0, "R11 stall released", 32'(core_stall), 32'd0);
        if (hld) chk(hold_ack == 1'b1, "R7 hold granted in idle", 32'(hold_ack), 32'd1);
        hold_req = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_valid == 1'b0 && bus_lock == 1'b0 && core_stall == 1'b0 && wbuf_drain == 1'b0
            && cache_inval == 1'b0, "reset state",
            {27'd0, cmd_valid, bus_lock, core_stall, wbuf_drain, cache_inval}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        // R12: a request is not taken while hold is pending in idle.
        hold_req = 1'b1;
        lock_req = 1'b1;
        lock_addr = 16'h1230;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk(hold_ack == 1'b1, "R7 hold granted in idle", 32'(hold_ack), 32'd1);
            chk(core_stall == 1'b0 && cmd_valid == 1'b0, "R12 request ignored under hold",
                {30'd0, core_stall, cmd_valid}, 32'd0);
        end
        lock_req = 1'b0;
        hold_req = 1'b0;
        @(posedge clk); @(negedge clk);

        // Sweep of read-modify-write configurations.
        for (int ls = 0; ls < 4; ls++)
            for (int lat = 0; lat < 3; lat++)
                for (int dd = 0; dd < 3; dd++)
                    for (int snp = 0; snp < 2; snp++)
                        run_seq(1'b0, 2'(ls), lat, dd, snp[0], 1'b0, 1'b0,
                                16'(16'h4000 + ls * 16'h100 + lat * 16'h10 + dd * 4 + snp));

        // Interrupt acknowledge on every line state.
        for (int ls = 0; ls < 3; ls++)
            run_seq(1'b1, 2'(ls), ls, 1, 1'b0, 1'b0, 1'b0, 16'(16'h8000 + ls * 16'h40));

        // Back-off with a pending hold request.
        for (int ls = 0; ls < 3; ls++)
            run_seq(1'b0, 2'(ls), 1, 1, 1'b0, 1'b1, 1'b1, 16'(16'hA000 + ls * 16'h20));
        run_seq(1'b1, 2'd2, 0, 0, 1'b0, 1'b1, 1'b1, 16'hB004);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule